// File: doc/BRIEF.md
# Acquisition Threshold Search Controller

This block makes the acquire-or-keep-searching decision for one satellite tracking channel. Once per code epoch, the correlator dumps its prompt in-phase and quadrature sums. The controller then scores them as |I| + |Q| and compares the score with a threshold that software programs. A score at or above the threshold declares the satellite acquired. The acquired flag latches and code-phase searching stops. A score below the threshold produces a one-cycle request to slip the local code by half a chip.

Each slip advances a sweep counter. When the counter has covered the programmed number of half-chip positions without a detection, the controller raises a one-cycle carrier step pulse alongside that final slip and restarts the count. Software or a carrier controller uses this pulse to move to the next Doppler bin. Software acknowledges a detection by clearing the flag, and the search then resumes from the code position where it stopped. A threshold set too high keeps the slips going every epoch, even past a genuine correlation peak.

Top module: `acq_search_ctrl`

## Requirements
- R1: After reset, `acquired`, `slip_req` and `carrier_step` are all 0, and the sweep counter is 0.
- R2: The score is |i_prompt| + |q_prompt|, with both inputs in two's complement, compared unsigned against `threshold`. A score greater than or equal to `threshold` on a cycle with `dump_valid` high sets `acquired` on the following cycle. This includes a score of zero against a threshold of zero, and inputs at the most negative value.
- R3: A dump whose score is below `threshold`, while not acquired, raises `slip_req` for exactly one cycle, the cycle after the dump. `slip_req` never rises without a dump on the preceding cycle.
- R4: While `acquired` is 1, dumps produce neither `slip_req` nor `carrier_step`, and the flag stays 1 until `ack_clear` is asserted.
- R5: `carrier_step` pulses for one cycle together with the `slip_req` of the slip that completes `sweep_len` slips. For example, with `sweep_len` = 2046 it pulses on the 2046th slip, and the following slip starts a new sweep.
- R6: The sweep counter holds its value while acquired and continues from that value after the flag is cleared.
- R7: `ack_clear` clears `acquired` on the following cycle. A dump in the same cycle as `ack_clear` is evaluated as though the flag were already clear.
- R8: A `sweep_len` of 0 or 1 makes every slip a carrier step. If `sweep_len` is lowered to or below the current count, the next slip produces a carrier step and restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dump_valid | input | 1 | One-cycle pulse marking a fresh prompt dump |
| i_prompt | input | CORR_W | Prompt in-phase correlation, two's complement |
| q_prompt | input | CORR_W | Prompt quadrature correlation, two's complement |
| threshold | input | CORR_W+1 | Detection threshold on \|I\|+\|Q\| |
| sweep_len | input | SLIP_W | Half-chip slips per Doppler bin |
| ack_clear | input | 1 | Software clear of the acquired flag |
| acquired | output | 1 | Latched detection flag |
| slip_req | output | 1 | One-cycle half-chip code delay request |
| carrier_step | output | 1 | One-cycle request to step the Doppler bin |

## Verification
The assertions assume that `dump_valid` is a single-cycle pulse separated from the next pulse by at least one idle cycle. They also assume that `threshold` and `sweep_len` change only between dumps. The bench drives every input on the falling edge and holds each dump for exactly one cycle. It changes the threshold and sweep length only while `dump_valid` is low, so every sampled decision sees settled operands.

// File: rtl/acq_pkg.sv
package acq_pkg;
    // Outcome of one epoch's evaluation
    typedef enum logic [1:0] {
        DEC_IDLE = 2'd0,   // no dump this cycle, or search halted
        DEC_HIT  = 2'd1,   // score met threshold
        DEC_MISS = 2'd2    // score below threshold: slip the code
    } acq_dec_e;
endpackage

// File: rtl/acq_metric.sv
module acq_metric #(
    parameter int CORR_W = 20
) (
    input  logic signed [CORR_W-1:0] i_val,
    input  logic signed [CORR_W-1:0] q_val,
    output logic        [CORR_W:0]   score
);
    localparam int ARMS = 2;

    logic signed [CORR_W-1:0] arm_in  [ARMS];
    logic        [CORR_W-1:0] arm_mag [ARMS];

    assign arm_in[0] = i_val;
    assign arm_in[1] = q_val;

    // Magnitude of each arm; the most negative code maps to 2^(CORR_W-1),
    // which still fits unsigned in CORR_W bits.
    for (genvar g = 0; g < ARMS; g++) begin : g_arm
        always_comb begin
            if (arm_in[g][CORR_W-1]) begin
                arm_mag[g] = CORR_W'(-arm_in[g]);
            end else begin
                arm_mag[g] = CORR_W'(arm_in[g]);
            end
        end
    end

    assign score = {1'b0, arm_mag[0]} + {1'b0, arm_mag[1]};
endmodule

// File: rtl/acq_slip_ctr.sv
module acq_slip_ctr #(
    parameter int SLIP_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc,
    input  logic [SLIP_W-1:0] limit,
    output logic              wrap,
    output logic [SLIP_W-1:0] cnt
);
    logic [SLIP_W-1:0] cnt_d, cnt_q;
    logic [SLIP_W:0]   nxt;

    always_comb begin
        nxt   = {1'b0, cnt_q} + 1'b1;
        // >= covers a limit of 0/1 and a limit lowered below the count
        wrap  = (nxt >= {1'b0, limit});
        cnt_d = cnt_q;
        if (inc) begin
            cnt_d = wrap ? '0 : nxt[SLIP_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt = cnt_q;

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(cnt_q)); // R6
endmodule

// File: rtl/acq_search_ctrl.sv
module acq_search_ctrl
    import acq_pkg::*;
#(
    parameter int CORR_W = 20,
    parameter int SLIP_W = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     dump_valid,
    input  logic signed [CORR_W-1:0] i_prompt,
    input  logic signed [CORR_W-1:0] q_prompt,
    input  logic        [CORR_W:0]   threshold,
    input  logic        [SLIP_W-1:0] sweep_len,
    input  logic                     ack_clear,
    output logic                     acquired,
    output logic                     slip_req,
    output logic                     carrier_step
);
    localparam int SCORE_W = CORR_W + 1;

    typedef struct packed {
        logic acq;
        logic slip;
        logic step;
    } ctl_t;

    ctl_t              st_d, st_q;
    logic [SCORE_W-1:0] score;
    acq_dec_e           dec;
    logic               acq_live;
    logic               slip_inc;
    logic               sweep_wrap;
    logic [SLIP_W-1:0]  sweep_cnt;

    acq_metric #(.CORR_W(CORR_W)) u_metric (
        .i_val (i_prompt),
        .q_val (q_prompt),
        .score (score)
    );

    acq_slip_ctr #(.SLIP_W(SLIP_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (slip_inc),
        .limit (sweep_len),
        .wrap  (sweep_wrap),
        .cnt   (sweep_cnt)
    );

    always_comb begin
        // a clear in this cycle lets the same-cycle dump be evaluated
        acq_live = st_q.acq && !ack_clear;
        dec      = DEC_IDLE;
        if (dump_valid && !acq_live) begin
            dec = (score >= threshold) ? DEC_HIT : DEC_MISS;
        end
        slip_inc  = (dec == DEC_MISS);
        st_d.acq  = acq_live || (dec == DEC_HIT);
        st_d.slip = slip_inc;
        st_d.step = slip_inc && sweep_wrap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acquired     = st_q.acq;
    assign slip_req     = st_q.slip;
    assign carrier_step = st_q.step;

    AST_SLIP_NEEDS_DUMP: assert property (@(posedge clk) disable iff (!rst_n)
        slip_req |-> $past(dump_valid)); // R3
    AST_SLIP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (slip_req && !dump_valid) |=> !slip_req); // R3
    AST_NO_SLIP_WHEN_ACQ: assert property (@(posedge clk) disable iff (!rst_n)
        acquired |-> !slip_req); // R4
    AST_ACQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (acquired && !ack_clear) |=> acquired); // R4
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_clear && !dump_valid) |=> !acquired); // R7
    AST_STEP_WITH_SLIP: assert property (@(posedge clk) disable iff (!rst_n)
        carrier_step |-> slip_req); // R5
    AST_FROZEN_WHILE_ACQ: assert property (@(posedge clk) disable iff (!rst_n)
        (acquired && !ack_clear) |=> $stable(sweep_cnt)); // R6
endmodule

// File: tb/test_acq_search_ctrl.sv
module test_acq_search_ctrl;
    localparam int CW = 20;
    localparam int SW = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              dump_valid = 1'b0;
    logic signed [CW-1:0] i_prompt = '0;
    logic signed [CW-1:0] q_prompt = '0;
    logic [CW:0]       threshold = '0;
    logic [SW-1:0]     sweep_len = '0;
    logic              ack_clear = 1'b0;
    logic              acquired, slip_req, carrier_step;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    acq_search_ctrl #(.CORR_W(CW), .SLIP_W(SW)) i_acq_search_ctrl (
        .clk(clk), .rst_n(rst_n), .dump_valid(dump_valid),
        .i_prompt(i_prompt), .q_prompt(q_prompt), .threshold(threshold),
        .sweep_len(sweep_len), .ack_clear(ack_clear),
        .acquired(acquired), .slip_req(slip_req), .carrier_step(carrier_step)
    );

    typedef struct packed {
        logic [CW-1:0] i;
        logic [CW-1:0] q;
        logic [CW:0]   th;
        logic          hit;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{CW'(100),     CW'(-50),     21'd150,     1'b1},
        '{CW'(100),     CW'(-50),     21'd151,     1'b0},
        '{CW'(-524288), CW'(0),       21'd524288,  1'b1},
        '{CW'(-524288), CW'(-524288), 21'd1048576, 1'b1},
        '{CW'(0),       CW'(0),       21'd0,       1'b1},
        '{CW'(0),       CW'(0),       21'd1,       1'b0},
        '{CW'(-3),      CW'(4),       21'd8,       1'b0},
        '{CW'(3),       CW'(-4),      21'd7,       1'b1}
    };

    task automatic chk(string req, string what, logic got, logic exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b", req, what, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        dump_valid = 1'b0;
        ack_clear = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // one-cycle dump; returns at the negedge where the registered result is visible
    task automatic dump(logic signed [CW-1:0] iv, logic signed [CW-1:0] qv);
        @(negedge clk);
        i_prompt   = iv;
        q_prompt   = qv;
        dump_valid = 1'b1;
        @(negedge clk);
        dump_valid = 1'b0;
    endtask

    task automatic clear_flag();
        @(negedge clk);
        ack_clear = 1'b1;
        @(negedge clk);
        ack_clear = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: reset state
        chk("R1", "acquired", acquired, 1'b0);
        chk("R1", "slip_req", slip_req, 1'b0);
        chk("R1", "carrier_step", carrier_step, 1'b0);

        // R2/R3 table walk
        sweep_len = 12'd2046;
        for (int k = 0; k < 8; k++) begin
            threshold = VEC[k].th;
            dump(VEC[k].i, VEC[k].q);
            chk("R2", $sformatf("vec%0d acquired", k), acquired, VEC[k].hit);
            chk("R3", $sformatf("vec%0d slip", k), slip_req, !VEC[k].hit);
            chk("R5", $sformatf("vec%0d step", k), carrier_step, 1'b0);
            if (VEC[k].hit) clear_flag();
        end

        // R3: slip is one cycle wide and needs a dump
        threshold = 21'h1FFFFF;
        dump(0, 0);
        chk("R3", "slip on miss", slip_req, 1'b1);
        @(negedge clk);
        chk("R3", "slip one cycle", slip_req, 1'b0);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk("R3", "no slip without dump", slip_req, 1'b0);
        end

        // R4/R7: latched flag, dumps ignored, clear
        threshold = 21'd10;
        dump(20, 0);
        chk("R4", "acquire", acquired, 1'b1);
        threshold = 21'h1FFFFF;
        for (int k = 0; k < 3; k++) begin
            dump(0, 0);
            chk("R4", "held acquired", acquired, 1'b1);
            chk("R4", "no slip while acquired", slip_req, 1'b0);
        end
        clear_flag();
        chk("R7", "clear drops flag", acquired, 1'b0);

        // R7: clear and dump in same cycle
        threshold = 21'd10;
        dump(20, 0);
        chk("R7", "reacquire", acquired, 1'b1);
        threshold = 21'h1FFFFF;
        @(negedge clk);
        ack_clear = 1'b1;
        dump_valid = 1'b1;
        i_prompt = 0;
        q_prompt = 0;
        @(negedge clk);
        ack_clear = 1'b0;
        dump_valid = 1'b0;
        chk("R7", "same-cycle flag", acquired, 1'b0);
        chk("R7", "same-cycle slip", slip_req, 1'b1);

        // R5: full sweep of 2046 slips
        do_reset();
        sweep_len = 12'd2046;
        threshold = 21'h1FFFFF;
        for (int k = 1; k <= 2046; k++) begin
            dump(0, 0);
            chk("R5", $sformatf("slip %0d step", k), carrier_step, (k == 2046));
        end
        dump(0, 0);
        chk("R5", "new sweep no step", carrier_step, 1'b0);

        // R6: counter freezes while acquired
        do_reset();
        sweep_len = 12'd5;
        threshold = 21'd10;
        dump(0, 0);
        dump(0, 0);
        dump(20, 0);
        chk("R6", "acquired mid-sweep", acquired, 1'b1);
        for (int k = 0; k < 3; k++) begin
            dump(0, 0);
            chk("R6", "no step while acquired", carrier_step, 1'b0);
        end
        clear_flag();
        dump(0, 0);
        chk("R6", "slip3 no step", carrier_step, 1'b0);
        dump(0, 0);
        chk("R6", "slip4 no step", carrier_step, 1'b0);
        dump(0, 0);
        chk("R6", "slip5 step", carrier_step, 1'b1);

        // R8: short and lowered sweep lengths
        do_reset();
        sweep_len = 12'd10;
        threshold = 21'h1FFFFF;
        dump(0, 0);
        dump(0, 0);
        dump(0, 0);
        chk("R8", "count 3 no step", carrier_step, 1'b0);
        sweep_len = 12'd2;
        dump(0, 0);
        chk("R8", "lowered limit step", carrier_step, 1'b1);
        sweep_len = 12'd1;
        dump(0, 0);
        chk("R8", "limit 1 step", carrier_step, 1'b1);
        sweep_len = 12'd0;
        dump(0, 0);
        chk("R8", "limit 0 step", carrier_step, 1'b1);
        chk("R8", "limit 0 slip", slip_req, 1'b1);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule